// File: doc/BRIEF.md
# Serial Auto-Baud Boot Handshake

This block sits on the receive and transmit lines of a boot-time serial link whose baud rate is not known in advance. After reset is released it ignores the receive line for a fixed settling window. It then times how long the line stays low during each 0x00 byte the host keeps sending. A 0x00 byte with its start bit holds the line low for nine bit times, so each measured low count, divided by nine and rounded to the nearest integer, gives a candidate bit period in clock cycles.

When two valid candidates in a row agree within a tolerance, the block locks that bit period. It uses the period to drive its own 8N1 transmitter and receiver. It sends one 0x00 acknowledge byte, then waits for one confirmation byte from the host. A correct 0x55 with a high stop bit raises the done flag. Any other outcome raises the fail flag and halts the block. There is no retry: only a new reset starts the sequence again.

Top module: `autobaud_boot`

## Requirements
- R1: While reset is held and just after it is released, `txd` is high, `locked`, `done` and `fail` are low, and `bitPeriod` is 0.
- R2: Low pulses on `rxd` that begin during the first `STARTUP_CYC` cycles after reset release take no part in measurement.
- R3: A measured low count L gives a candidate period of (L+4)/9, rounded down. The candidate is locked into `bitPeriod`, and `locked` goes high, when it differs from the previous valid candidate by no more than that previous candidate shifted right by `TOL_SHIFT`.
- R4: A valid candidate that falls outside the tolerance does not lock. It replaces the previous candidate as the reference for the next low pulse.
- R5: A low count below `MIN_LOW` or above `MAX_LOW` is discarded and clears the reference, so the two valid low pulses on either side of it are not compared. Counts equal to either limit are valid.
- R6: After locking, `txd` carries exactly one 8N1 frame, least significant bit first: a low start bit, eight data bits of 0x00 and a high stop bit, each `bitPeriod` cycles long. Outside that frame `txd` is high.
- R7: After the acknowledge frame, a received byte equal to 0x55 (bits sampled at mid-bit, least significant bit first) with a high stop bit raises `done`, which stays high until reset.
- R8: A received byte with any value other than 0x55 raises `fail` and leaves `done` low.
- R9: A received stop bit that samples low raises `fail`, even when the data byte is 0x55.
- R10: `fail` stays high, with `txd` idle high, until reset. A new reset clears it and restarts the whole sequence.
- R11: Once locked, `bitPeriod` does not change until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset; release with `rxd` high |
| rxd | input | 1 | Serial receive line from the host, idle high |
| txd | output | 1 | Serial transmit line to the host, idle high |
| bitPeriod | output | CNT_W | Locked bit period in clock cycles (0 before lock) |
| locked | output | 1 | Bit period has been locked |
| done | output | 1 | Handshake completed correctly |
| fail | output | 1 | Handshake failed; halted until reset |

## Verification
The bench builds the block with `CNT_W`=16, `STARTUP_CYC`=100, `MIN_LOW`=36, `MAX_LOW`=1800 and `TOL_SHIFT`=4. The low `MAX_LOW` puts an over-long pulse, and the exact limits 1800 and 1801, within a few thousand cycles. These values allow a full handshake for every bit period from 4 to 40 cycles. They also allow a sweep of every low count from 36 to 120 to check the rounding. The tolerance of one sixteenth applied to a 32-cycle period gives the edge cases of 2 cycles accepted and 3 rejected on both sides.

// File: rtl/autobaud_pkg.sv
package autobaud_pkg;

  typedef enum logic [2:0] {
    ST_WAKE,
    ST_MEASURE,
    ST_LOADTX,
    ST_SEND,
    ST_WAITRX,
    ST_RXBYTE,
    ST_DONE,
    ST_HALT
  } abState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic measEn;
    logic txStart;
    logic txActive;
    logic rxStart;
    logic rxActive;
  } abStrobe_t;

  localparam logic [7:0] ACK_BYTE     = 8'h00;
  localparam logic [7:0] CONFIRM_BYTE = 8'h55;
  localparam int         FRAME_BITS   = 10;
  localparam int         ZERO_LOW_BITS = 9;

endpackage

// File: rtl/autobaud_dpath.sv
module autobaud_dpath
  import autobaud_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int MIN_LOW   = 36,
  parameter int MAX_LOW   = 36000,
  parameter int TOL_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxd,
  input  abStrobe_t        strb,
  output logic             txd,
  output logic [CNT_W-1:0] bitPeriod,
  output logic             lockNow,
  output logic             fallEdge,
  output logic             txDone,
  output logic             rxDone,
  output logic             rxOk
);

  localparam logic [CNT_W:0]   DIVISOR  = (CNT_W+1)'(ZERO_LOW_BITS);
  localparam logic [CNT_W:0]   ROUNDADD = (CNT_W+1)'(ZERO_LOW_BITS / 2);
  localparam logic [CNT_W-1:0] MIN_CNT  = CNT_W'(MIN_LOW);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(MAX_LOW);
  localparam logic [CNT_W-1:0] MIN_P    = CNT_W'((MIN_LOW + ZERO_LOW_BITS / 2) / ZERO_LOW_BITS);
  localparam logic [CNT_W-1:0] MAX_P    = CNT_W'((MAX_LOW + ZERO_LOW_BITS / 2) / ZERO_LOW_BITS);
  localparam logic [3:0]       LAST_BIT = 4'(FRAME_BITS - 1);

  // input synchroniser and edge detection
  logic rxMeta, rxS, rxPrev, riseEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxS    <= 1'b1;
      rxPrev <= 1'b1;
    end else begin
      rxMeta <= rxd;
      rxS    <= rxMeta;
      rxPrev <= rxS;
    end
  end

  assign fallEdge = rxPrev & ~rxS;
  assign riseEdge = ~rxPrev & rxS;

  // low-period measurement
  logic             lowActive, prevValid;
  logic [CNT_W-1:0] lowCnt, prevPer, bitPer;
  logic [CNT_W-1:0] curPer, perDiff, tolWin;
  logic [CNT_W:0]   roundSum;
  logic             measValid, agree, evalNow;

  always_comb begin
    roundSum  = {1'b0, lowCnt} + ROUNDADD;
    curPer    = CNT_W'(roundSum / DIVISOR);
    perDiff   = (curPer >= prevPer) ? (curPer - prevPer) : (prevPer - curPer);
    tolWin    = prevPer >> TOL_SHIFT;
    measValid = (lowCnt >= MIN_CNT) && (lowCnt <= MAX_CNT);
    agree     = prevValid && (perDiff <= tolWin);
    evalNow   = strb.measEn && lowActive && riseEdge;
  end

  assign lockNow = evalNow && measValid && agree;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowActive <= 1'b0;
      lowCnt    <= '0;
      prevPer   <= '0;
      prevValid <= 1'b0;
      bitPer    <= '0;
    end else if (!strb.measEn) begin
      lowActive <= 1'b0;
      lowCnt    <= '0;
    end else if (fallEdge) begin
      lowActive <= 1'b1;
      lowCnt    <= CNT_W'(1);
    end else if (lowActive && !rxS) begin
      if (lowCnt != '1) lowCnt <= lowCnt + 1'b1;
    end else if (evalNow) begin
      lowActive <= 1'b0;
      if (!measValid) begin
        prevValid <= 1'b0;
      end else if (agree) begin
        bitPer <= curPer;
      end else begin
        prevPer   <= curPer;
        prevValid <= 1'b1;
      end
    end
  end

  assign bitPeriod = bitPer;

  // shared bit-timing engine for transmit and receive
  logic [CNT_W-1:0] cycCnt;
  logic [3:0]       bitIdx;
  logic [7:0]       shReg;
  logic             txReg, tick;

  assign tick   = (cycCnt == '0);
  assign txDone = strb.txActive && tick && (bitIdx == LAST_BIT);
  assign rxDone = strb.rxActive && tick && (bitIdx == LAST_BIT);
  assign rxOk   = rxDone && rxS && (shReg == CONFIRM_BYTE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cycCnt <= '0;
      bitIdx <= '0;
      shReg  <= '0;
      txReg  <= 1'b1;
    end else if (strb.txStart) begin
      cycCnt <= bitPer - 1'b1;
      bitIdx <= '0;
      txReg  <= 1'b0;
    end else if (strb.rxStart) begin
      cycCnt <= (bitPer >> 1) - 1'b1;
      bitIdx <= '0;
    end else if (strb.txActive || strb.rxActive) begin
      if (tick) begin
        if (bitIdx != LAST_BIT) begin
          bitIdx <= bitIdx + 1'b1;
          cycCnt <= bitPer - 1'b1;
          if (strb.txActive)
            txReg <= (bitIdx < 4'd8) ? ACK_BYTE[bitIdx[2:0]] : 1'b1;
        end
        if (strb.rxActive && bitIdx != 4'd0 && bitIdx != LAST_BIT)
          shReg <= {rxS, shReg[7:1]};
      end else begin
        cycCnt <= cycCnt - 1'b1;
      end
    end
  end

  assign txd = txReg;

  // R6: line idles high outside the transmit frame
  p_idle_high_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.txActive |-> txd);

  // R11: locked period never moves once measurement has ended
  p_period_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.measEn && !$past(strb.measEn)) |-> $stable(bitPer));

  // R5: the period used for transmission lies within the valid range
  p_period_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.txStart |-> (bitPer >= MIN_P && bitPer <= MAX_P));

endmodule

// File: rtl/autobaud_ctrl.sv
module autobaud_ctrl
  import autobaud_pkg::*;
#(
  parameter int STARTUP_CYC = 100
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      lockNow,
  input  logic      fallEdge,
  input  logic      txDone,
  input  logic      rxDone,
  input  logic      rxOk,
  output abStrobe_t strb,
  output logic      locked,
  output logic      done,
  output logic      fail
);

  localparam int WAKE_W = $clog2(STARTUP_CYC + 1);
  localparam logic [WAKE_W-1:0] WAKE_LAST = WAKE_W'(STARTUP_CYC - 1);

  abState_e          state, nxt;
  logic [WAKE_W-1:0] wakeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_WAKE;
      wakeCnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_WAKE) wakeCnt <= wakeCnt + 1'b1;
    end
  end

  always_comb begin
    nxt  = state;
    strb = '0;
    case (state)
      ST_WAKE:    if (wakeCnt == WAKE_LAST) nxt = ST_MEASURE;
      ST_MEASURE: begin
        strb.measEn = 1'b1;
        if (lockNow) nxt = ST_LOADTX;
      end
      ST_LOADTX: begin
        strb.txStart = 1'b1;
        nxt = ST_SEND;
      end
      ST_SEND: begin
        strb.txActive = 1'b1;
        if (txDone) nxt = ST_WAITRX;
      end
      ST_WAITRX: if (fallEdge) begin
        strb.rxStart = 1'b1;
        nxt = ST_RXBYTE;
      end
      ST_RXBYTE: begin
        strb.rxActive = 1'b1;
        if (rxDone) nxt = rxOk ? ST_DONE : ST_HALT;
      end
      default: ;
    endcase
  end

  assign locked = (state != ST_WAKE) && (state != ST_MEASURE);
  assign done   = (state == ST_DONE);
  assign fail   = (state == ST_HALT);

  // R7: success is final until reset
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  // R10: failure is final until reset
  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    fail |=> fail);

  // R3: lock is only ever gained, never dropped
  p_lock_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> locked);

endmodule

// File: rtl/autobaud_boot.sv
module autobaud_boot
  import autobaud_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STARTUP_CYC = 100,
  parameter int MIN_LOW     = 36,
  parameter int MAX_LOW     = 36000,
  parameter int TOL_SHIFT   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxd,
  output logic             txd,
  output logic [CNT_W-1:0] bitPeriod,
  output logic             locked,
  output logic             done,
  output logic             fail
);

  abStrobe_t strb;
  logic lockNow, fallEdge, txDone, rxDone, rxOk;

  autobaud_ctrl #(.STARTUP_CYC(STARTUP_CYC)) ctrl_i (
    .clk(clk), .rstN(rstN), .lockNow(lockNow), .fallEdge(fallEdge),
    .txDone(txDone), .rxDone(rxDone), .rxOk(rxOk), .strb(strb),
    .locked(locked), .done(done), .fail(fail)
  );

  autobaud_dpath #(
    .CNT_W(CNT_W), .MIN_LOW(MIN_LOW), .MAX_LOW(MAX_LOW), .TOL_SHIFT(TOL_SHIFT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .rxd(rxd), .strb(strb), .txd(txd),
    .bitPeriod(bitPeriod), .lockNow(lockNow), .fallEdge(fallEdge),
    .txDone(txDone), .rxDone(rxDone), .rxOk(rxOk)
  );

endmodule

// File: tb/autobaud_boot_tb_top.sv
module autobaud_boot_tb_top;

  localparam int CNT_W = 16;
  localparam int STARTUP = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxd = 1'b1;
  logic txd, locked, done, fail;
  logic [CNT_W-1:0] bitPeriod;

  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  autobaud_boot #(
    .CNT_W(CNT_W), .STARTUP_CYC(STARTUP), .MIN_LOW(36), .MAX_LOW(1800), .TOL_SHIFT(4)
  ) dut_i (
    .clk(clk), .rstN(rstN), .rxd(rxd), .txd(txd), .bitPeriod(bitPeriod),
    .locked(locked), .done(done), .fail(fail)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    rxd  = 1'b1;
    repeat (3) @(negedge clk);
    checkEq("R1 txd in reset", int'(txd), 1);
    checkEq("R1 flags in reset", int'({locked, done, fail}), 0);
    checkEq("R1 period in reset", int'(bitPeriod), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkEq("R1 flags after release", int'({locked, done, fail, txd}), 1);
  endtask

  task automatic settle();
    repeat (STARTUP + 10) @(negedge clk);
  endtask

  task automatic lowPulse(input int lowLen, input int highLen);
    rxd = 1'b0;
    repeat (lowLen) @(negedge clk);
    rxd = 1'b1;
    repeat (highLen) @(negedge clk);
  endtask

  task automatic sendByte(input logic [7:0] b, input int p, input logic stopBit);
    for (int k = 0; k < 10; k++) begin
      rxd = (k == 0) ? 1'b0 : (k == 9) ? stopBit : b[k-1];
      repeat (p) @(negedge clk);
    end
    rxd = 1'b1;
  endtask

  task automatic recvByte(input int p, output logic [7:0] b, output logic startV,
                          output logic stopV);
    @(negedge clk);
    while (txd !== 1'b0) @(negedge clk);
    repeat (p / 2) @(negedge clk);
    startV = txd;
    for (int k = 0; k < 8; k++) begin
      repeat (p) @(negedge clk);
      b[k] = txd;
    end
    repeat (p) @(negedge clk);
    stopV = txd;
  endtask

  task automatic expectLock(input string tag, input int expPer);
    repeat (4) @(negedge clk);
    checkEq({tag, " locked"}, int'(locked), 1);
    checkEq({tag, " period"}, int'(bitPeriod), expPer);
  endtask

  task automatic expectNoLock(input string tag);
    repeat (4) @(negedge clk);
    checkEq({tag, " not locked"}, int'(locked), 0);
  endtask

  task automatic fullRun(input int p, input logic [7:0] reply, input logic stopBit,
                         input bit expOk, input string tag);
    logic [7:0] ack;
    logic sV, eV;
    doReset();
    settle();
    fork
      begin
        sendByte(8'h00, p, 1'b1);
        sendByte(8'h00, p, 1'b1);
      end
      recvByte(p, ack, sV, eV);
    join
    checkEq("R3 swept period", int'(bitPeriod), p);
    checkEq("R6 ack data", int'(ack), 0);
    checkEq("R6 ack start/stop", int'({sV, eV}), 1);
    repeat (p) @(negedge clk);
    sendByte(reply, p, stopBit);
    repeat (4) @(negedge clk);
    checkEq({tag, " done"}, int'(done), expOk ? 1 : 0);
    checkEq({tag, " fail"}, int'(fail), expOk ? 0 : 1);
    checkEq("R11 period held", int'(bitPeriod), p);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : stim
    // R7 / R6 / R3: full handshake over a range of bit periods
    for (int p = 4; p <= 40; p++) fullRun(p, 8'h55, 1'b1, 1'b1, "R7 good reply");

    // R8: wrong values
    fullRun(8, 8'h54, 1'b1, 1'b0, "R8 reply 0x54");
    fullRun(12, 8'hD5, 1'b1, 1'b0, "R8 reply 0xD5");
    // R10: failure persists, line idle
    repeat (200) @(negedge clk);
    checkEq("R10 fail persists", int'(fail), 1);
    checkEq("R10 txd idle in halt", int'(txd), 1);
    checkEq("R10 done low in halt", int'(done), 0);
    // R9: low stop bit
    fullRun(9, 8'h55, 1'b0, 1'b0, "R9 framing");
    // R10: a fresh reset restarts
    fullRun(6, 8'h55, 1'b1, 1'b1, "R10 restart");

    // R3 rounding sweep over low counts
    for (int l = 36; l <= 120; l++) begin
      doReset();
      settle();
      lowPulse(l, 20);
      checkEq("R3 single pulse no lock", int'(locked), 0);
      lowPulse(l, 20);
      expectLock("R3 rounding", (l + 4) / 9);
    end

    // R2: pulse inside the startup window is ignored
    doReset();
    lowPulse(72, 5);
    repeat (STARTUP) @(negedge clk);
    lowPulse(72, 20);
    expectNoLock("R2 window pulse ignored");
    lowPulse(72, 20);
    expectLock("R2 after window", 8);

    // R4: tolerance edges around 32
    doReset(); settle();
    lowPulse(288, 20); lowPulse(306, 20);
    expectLock("R4 +2 accepted", 34);
    doReset(); settle();
    lowPulse(288, 20); lowPulse(270, 20);
    expectLock("R4 -2 accepted", 30);
    doReset(); settle();
    lowPulse(288, 20); lowPulse(315, 20);
    expectNoLock("R4 +3 rejected");
    lowPulse(315, 20);
    expectLock("R4 new reference", 35);
    doReset(); settle();
    lowPulse(288, 20); lowPulse(261, 20);
    expectNoLock("R4 -3 rejected");

    // R5: out-of-range pulses
    doReset(); settle();
    lowPulse(2250, 20); lowPulse(90, 20);
    expectNoLock("R5 long pulse discarded");
    lowPulse(90, 20);
    expectLock("R5 after long", 10);
    doReset(); settle();
    lowPulse(90, 20); lowPulse(27, 20); lowPulse(90, 20);
    expectNoLock("R5 short pulse breaks pair");
    lowPulse(90, 20);
    expectLock("R5 after short", 10);
    doReset(); settle();
    lowPulse(35, 20); lowPulse(35, 20); lowPulse(35, 20);
    expectNoLock("R5 below minimum");
    doReset(); settle();
    lowPulse(1801, 20); lowPulse(1801, 20);
    expectNoLock("R5 above maximum");
    doReset(); settle();
    lowPulse(1800, 20); lowPulse(1800, 20);
    expectLock("R5 at maximum", 200);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule